// File: doc/BRIEF.md
# Program/Erase Completion Status Reporter

This block supplies the byte returned on a read while a nonvolatile array is busy with an internal program or erase operation. Software polls the ordinary read path to learn when the operation ends. No separate status register is needed.

The block keeps two pieces of state:

- **Captured byte and mode.** It holds the most recent byte loaded for programming. A program load records that byte and selects program mode. An erase start selects erase mode.
- **Flip bit.** A single flop inverts on every read strobe that arrives while busy.

While busy, each read returns a status byte:

- the top bit carries the inverse of the value being written;
- the next bit carries the flip bit, so successive reads alternate;
- the remaining bits are zero.

Once busy drops, a read returns the array data unchanged, and the flip bit stays at whatever value it last held.

The read result is registered. It is taken on the cycle of the read strobe, appears on `rd_data_o` one cycle later, and holds until the next strobe.

Top module: `pe_status_rd`

## Requirements
- R1: After reset, `rd_data_o` is 8'h00 and the flip bit is 0, so the first busy read returns bit 6 = 1.
- R2: A strobe while busy in program mode makes `rd_data_o[7]` equal the inverse of bit 7 of the last loaded byte on the following cycle.
- R3: A strobe while busy in erase mode makes `rd_data_o[7]` equal 0 on the following cycle.
- R4: Each successive strobe while busy returns `rd_data_o[6]` inverted from the previous busy read.
- R5: A strobe while busy returns `rd_data_o[5:0]` equal to 0.
- R6: A strobe while not busy returns all eight bits of `array_data_i` as sampled in the strobe cycle, on the following cycle.
- R7: The flip bit does not change on idle reads or idle cycles. The first busy read of a new operation returns bit 6 inverted from the last busy read of the previous operation.
- R8: Without a strobe, `rd_data_o` holds its value, even if the array data or the busy state change.
- R9: Mode and byte follow the most recent event. A later program load replaces the captured byte, and a later erase start or program load selects the corresponding mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Internal program or erase in progress |
| prog_load_i | input | 1 | Single-cycle pulse: program byte loaded |
| prog_data_i | input | 8 | Byte being programmed |
| erase_start_i | input | 1 | Single-cycle pulse: erase started |
| rd_stb_i | input | 1 | Single-cycle read access pulse |
| array_data_i | input | 8 | True array read data |
| rd_data_o | output | 8 | Read data returned to the bus |

## Verification
The assertions in the RTL check on every cycle:

- that the output holds between strobes;
- that the flip bit inverts on a busy strobe and stays put otherwise;
- that a busy read zeroes the low bits and drives the correct top bit for the mode;
- that an idle read returns the sampled array byte.

Only the bench scenarios show the sequence-level behaviour:

- the flip bit carrying across separate operations;
- the last load winning when loads and erase starts are mixed;
- the first busy read after reset showing bit 6 = 1.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;
  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} op_e;
endpackage

// File: rtl/pe_op_capture.sv
module pe_op_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_load_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              erase_start_i,
  output logic [DATA_W-1:0] cap_data_o,
  output pe_status_pkg::op_e op_o
);
  import pe_status_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_data_o <= '0;
      op_o       <= OP_PROG;
    end else if (prog_load_i) begin
      cap_data_o <= prog_data_i;
      op_o       <= OP_PROG;
    end else if (erase_start_i) begin
      op_o       <= OP_ERASE;
    end
  end

  assert_erase_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_start_i && !prog_load_i) |=> (op_o == OP_ERASE));
endmodule

// File: rtl/pe_flip_bit.sv
module pe_flip_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic flip_o,
  output logic flip_nxt_o
);
  logic flip_q;

  assign flip_nxt_o = ~flip_q;
  assign flip_o     = flip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flip_q <= 1'b0;
    else if (adv_i) flip_q <= flip_nxt_o;
  end

  assert_flip_adv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (flip_q != $past(flip_q)));
  assert_flip_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(flip_q));
endmodule

// File: rtl/pe_status_mux.sv
module pe_status_mux #(
  parameter int DATA_W = 8
) (
  input  logic               busy_i,
  input  pe_status_pkg::op_e op_i,
  input  logic [DATA_W-1:0]  cap_data_i,
  input  logic               flip_i,
  input  logic [DATA_W-1:0]  array_data_i,
  output logic [DATA_W-1:0]  data_o
);
  import pe_status_pkg::*;
  localparam int POLL_BIT = DATA_W - 1;
  localparam int FLIP_BIT = DATA_W - 2;

  always_comb begin
    if (busy_i) begin
      data_o           = '0;
      // erased cells read 1, so the inverse is 0
      data_o[POLL_BIT] = (op_i == OP_ERASE) ? 1'b0 : ~cap_data_i[POLL_BIT];
      data_o[FLIP_BIT] = flip_i;
    end else begin
      data_o = array_data_i;
    end
  end
endmodule

// File: rtl/pe_status_rd.sv
module pe_status_rd #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              prog_load_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              erase_start_i,
  input  logic              rd_stb_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  import pe_status_pkg::*;
  localparam int POLL_BIT = DATA_W - 1;
  localparam int FLIP_BIT = DATA_W - 2;

  logic [DATA_W-1:0] cap_data;
  op_e               op;
  logic              flip, flip_nxt, busy_rd;
  logic [DATA_W-1:0] mux_data;

  assign busy_rd = rd_stb_i & busy_i;

  pe_op_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i, .rst_ni, .prog_load_i, .prog_data_i, .erase_start_i,
    .cap_data_o(cap_data), .op_o(op)
  );

  pe_flip_bit u_flip (
    .clk_i, .rst_ni, .adv_i(busy_rd), .flip_o(flip), .flip_nxt_o(flip_nxt)
  );

  // the read reports the flip value after this access advances it
  pe_status_mux #(.DATA_W(DATA_W)) u_mux (
    .busy_i, .op_i(op), .cap_data_i(cap_data), .flip_i(flip_nxt),
    .array_data_i, .data_o(mux_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_data_o <= '0;
    else if (rd_stb_i) rd_data_o <= mux_data;
  end

  assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stb_i |=> $stable(rd_data_o));
  assert_idle_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && !busy_i) |=> (rd_data_o == $past(array_data_i)));
  assert_busy_low_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_rd |=> (rd_data_o[FLIP_BIT-1:0] == '0));
  assert_erase_poll_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_rd && op == OP_ERASE) |=> !rd_data_o[POLL_BIT]);
  assert_prog_poll_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_rd && op == OP_PROG) |=> (rd_data_o[POLL_BIT] != $past(cap_data[POLL_BIT])));
endmodule

// File: tb/sim_pe_status_rd.sv
module sim_pe_status_rd;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 1'b0, pload = 1'b0, estart = 1'b0, rd = 1'b0;
  logic [7:0] pdata = '0, arr = '0;
  logic [7:0] dout;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       m_flip = 1'b0, m_erase = 1'b0;
  logic [7:0] m_cap = '0;
  logic       chk_pend = 1'b0;
  logic       last_b6;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  pe_status_rd u0 (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .prog_load_i(pload),
    .prog_data_i(pdata), .erase_start_i(estart), .rd_stb_i(rd),
    .array_data_i(arr), .rd_data_o(dout)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] d);
    @(negedge clk); pload = 1'b1; pdata = d;
    @(negedge clk); pload = 1'b0;
    m_cap = d; m_erase = 1'b0;
  endtask

  task automatic do_erase();
    @(negedge clk); estart = 1'b1;
    @(negedge clk); estart = 1'b0;
    m_erase = 1'b1;
  endtask

  task automatic do_read(input string tag);
    logic [7:0] e;
    @(negedge clk);
    if (busy) begin
      m_flip = ~m_flip;
      e = {m_erase ? 1'b0 : ~m_cap[7], m_flip, 6'b0};
    end else e = arr;
    exp_q.push_back(e); tag_q.push_back(tag);
    rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  // monitor: pops one expected entry per strobe, compares one cycle later
  always @(posedge clk) if (rd) chk_pend <= 1'b1;
  always @(negedge clk) begin
    if (chk_pend) begin
      chk_pend <= 1'b0;
      if (exp_q.size() > 0) check(tag_q.pop_front(), dout, exp_q.pop_front());
      else check("queue underflow", dout, 8'hxx);
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset output", dout, 8'h00);
    rst_n = 1'b1;

    // R6 idle reads pass data through
    arr = 8'hA5; do_read("R6 idle A5");
    arr = 8'h3C; do_read("R6 idle 3C");

    // R2 R4 R5 program polling, bit7=1 -> reads 0; R1 first flip gives 1
    do_load(8'h80); busy = 1'b1;
    do_read("R1 R2 R5 first busy read");
    do_read("R4 second busy read");
    do_read("R4 third busy read");
    // R8 hold without strobe while array and busy change
    @(negedge clk); last_b6 = dout[6]; arr = 8'hFF; busy = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 hold no strobe", dout, {1'b0, last_b6, 6'b0});
    arr = 8'h80; do_read("R6 completion true data");
    do_read("R7 idle read keeps flip");

    // R2 bit7=0 -> reads 1; R7 flip continues across operations
    do_load(8'h12); busy = 1'b1;
    do_read("R2 R7 new op first read");
    do_read("R4 alternate");
    busy = 1'b0;

    // R3 erase polling
    do_erase(); busy = 1'b1;
    do_read("R3 erase read");
    do_read("R3 R4 erase read 2");
    busy = 1'b0; arr = 8'hFF; do_read("R6 erased data");

    // R9 load after erase returns to program mode with new byte
    do_erase(); do_load(8'h7F); busy = 1'b1;
    do_read("R9 last event program");
    busy = 1'b0;
    do_load(8'h00); do_erase(); busy = 1'b1;
    do_read("R9 last event erase");
    busy = 1'b0;
    do_load(8'hFF); do_load(8'h01); busy = 1'b1;
    do_read("R9 latest byte wins");
    busy = 1'b0;

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule